// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is an SPI master (mode 0) that runs one full-duplex burst each time software starts it. Two counts define the burst. The burst count is the total number of bytes clocked while chip select is low. The transmit count is how many of the leading bytes are taken from the transmit FIFO. Once the transmit count is used up, the engine shifts out zero filler bytes, so a single burst can send a command header and then read a response of any length.

Every byte clocked in on MISO is stored in the receive FIFO. This includes the bytes captured while the header was going out, so software normally discards the first few entries.

Software reaches the block through a simple register port. A write strobe with an address writes a register. The read data is combinational on the address. A read strobe on the receive-data address pops one byte from the receive FIFO.

Register map (3-bit address):
- 0: control
- 1: clock half-period
- 2: burst count
- 3: transmit count
- 4: status
- 5: transmit data (write only)
- 6: receive data (read only)

Top module: `spi_burst_master`

## Requirements
- R1: After reset, CS_n reads 1, SCLK and MOSI read 0, the control register reads 0, the half-period register reads 2 and the status register reads 0.
- R2: A burst keeps CS_n low throughout and gives exactly 8 × burst-count rising SCLK edges. After the last falling edge, CS_n returns high and control bit 4 (exchange) reads 0 again.
- R3: Each byte goes out MSB first. For byte index i, the byte sent is the next transmit FIFO entry when i is below the transmit count and the FIFO holds data. Otherwise the byte sent is 0x00.
- R4: MISO is sampled on each rising SCLK edge, MSB first. Every completed byte is pushed into the receive FIFO, and reads of address 6 return those bytes in arrival order.
- R5: Status bits [6:0] give the receive FIFO level, bits [14:8] give the transmit FIFO level, and bit 16 reads 1 while a burst runs.
- R6: The SCLK period is 2 × H input clock cycles, where H is the half-period register, and H = 0 acts as 1. The reset value of 2 therefore divides the input clock by 4.
- R7: A burst starts only when a control write sets bit 4 together with bit 0 (enable) and bit 1 (master). If either of those bits is 0, or the burst count is 0, the write starts nothing and bit 4 reads 0.
- R8: Writing control bit 31 starts a soft reset. Bit 31 then reads 1 for SRST_CYCLES cycles and then 0. During the soft reset, any burst is stopped, both FIFOs are emptied, and the burst and transmit counts become 0.
- R9: Control bit 2 empties only the transmit FIFO. Control bit 3 empties only the receive FIFO.
- R10: Each FIFO holds 64 bytes. A transmit write to a full FIFO is dropped. A received byte that arrives when the receive FIFO is full is dropped, and the bytes already stored are kept.
- R11: While no burst runs, SCLK and MOSI are 0 and CS_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive FIFO at address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A wrong byte or bit counter shows up at the pins as the wrong number of SCLK rising edges under one CS_n low window. The same fault also leaves the receive FIFO level unequal to the burst count; both are visible as soon as the exchange bit clears. A wrong transmit-count decrement shows up as a header byte replaced by filler, or filler replaced by stale FIFO data, on the first affected byte. Divider faults show up as the wrong spacing between the first two SCLK rising edges.

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master #(
  parameter int FIFO_DEPTH  = 64,
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 8,
  parameter int DIV_RESET   = 2,
  parameter int SRST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);

  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int LVL_W = PTR_W + 1;
  localparam int SR_W  = $clog2(SRST_CYCLES + 1);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_DEPTH);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_HALF = 3'd1;
  localparam logic [2:0] A_BRST = 3'd2;
  localparam logic [2:0] A_TXC  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_TXD  = 3'd5;
  localparam logic [2:0] A_RXD  = 3'd6;

  // configuration
  logic             en_q, mst_q;
  logic [DIV_W-1:0] half_q;
  logic [CNT_W-1:0] burst_q, txcnt_q;
  logic [SR_W-1:0]  sr_cnt;
  wire              sr_act = (sr_cnt != '0);

  // fifos
  logic [7:0]       txm [FIFO_DEPTH];
  logic [7:0]       rxm [FIFO_DEPTH];
  logic [PTR_W-1:0] txw, txr, rxw, rxr;
  logic [LVL_W-1:0] txl, rxl;

  // engine
  logic             busy, cs_q, sclk_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] dcnt;
  logic [CNT_W-1:0] left_q, txleft_q;
  logic [7:0]       sh_tx, sh_rx;

  wire unused_wbits = ^reg_wdata[30:8];

  wire wr_ctrl = reg_we && (reg_addr == A_CTRL) && !sr_act;
  wire start   = wr_ctrl && reg_wdata[4] && reg_wdata[0] && reg_wdata[1] &&
                 !reg_wdata[31] && !busy && (burst_q != '0);

  wire [DIV_W-1:0] half_v = (half_q == '0) ? DIV_W'(1) : half_q;
  wire tick     = busy && (dcnt == half_v - DIV_W'(1));
  wire rise     = tick && !sclk_q;
  wire fall     = tick && sclk_q;
  wire byte_end = fall && (bit_q == 3'd7);
  wire last     = byte_end && (left_q == CNT_W'(1));
  wire load     = start || (byte_end && !last);

  wire [CNT_W-1:0] tl_src = start ? txcnt_q : txleft_q;
  wire tx_pop  = load && (tl_src != '0) && (txl != '0);
  wire [7:0] nxt_byte = tx_pop ? txm[txr] : 8'h00;

  wire tx_push = reg_we && (reg_addr == A_TXD) && !sr_act && (txl != FULL);
  wire tx_clr  = sr_act || (wr_ctrl && reg_wdata[2]);
  wire rx_push = byte_end && (rxl != FULL);
  wire rx_pop  = reg_re && (reg_addr == A_RXD) && !sr_act && (rxl != '0);
  wire rx_clr  = sr_act || (wr_ctrl && reg_wdata[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mst_q   <= 1'b0;
      half_q  <= DIV_W'(DIV_RESET);
      burst_q <= '0;
      txcnt_q <= '0;
      sr_cnt  <= '0;
    end else if (sr_act) begin
      sr_cnt  <= sr_cnt - SR_W'(1);
      burst_q <= '0;
      txcnt_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          en_q  <= reg_wdata[0];
          mst_q <= reg_wdata[1];
          if (reg_wdata[31]) sr_cnt <= SR_W'(SRST_CYCLES);
        end
        A_HALF:  half_q  <= reg_wdata[DIV_W-1:0];
        A_BRST:  burst_q <= reg_wdata[CNT_W-1:0];
        A_TXC:   txcnt_q <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[txw] <= reg_wdata[7:0];
    if (rx_push) rxm[rxw] <= sh_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txw <= '0; txr <= '0; txl <= '0;
    end else if (tx_clr) begin
      txw <= '0; txr <= '0; txl <= '0;
    end else begin
      if (tx_push) txw <= txw + PTR_W'(1);
      if (tx_pop)  txr <= txr + PTR_W'(1);
      txl <= txl + LVL_W'(tx_push) - LVL_W'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxw <= '0; rxr <= '0; rxl <= '0;
    end else if (rx_clr) begin
      rxw <= '0; rxr <= '0; rxl <= '0;
    end else begin
      if (rx_push) rxw <= rxw + PTR_W'(1);
      if (rx_pop)  rxr <= rxr + PTR_W'(1);
      rxl <= rxl + LVL_W'(rx_push) - LVL_W'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cs_q <= 1'b1; sclk_q <= 1'b0;
      bit_q <= '0; dcnt <= '0; left_q <= '0; txleft_q <= '0;
      sh_tx <= '0; sh_rx <= '0;
    end else if (sr_act) begin
      busy <= 1'b0; cs_q <= 1'b1; sclk_q <= 1'b0;
      bit_q <= '0; dcnt <= '0; left_q <= '0; txleft_q <= '0;
      sh_tx <= '0; sh_rx <= '0;
    end else begin
      if (start) begin
        busy   <= 1'b1;
        cs_q   <= 1'b0;
        sclk_q <= 1'b0;
        dcnt   <= '0;
        bit_q  <= '0;
        left_q <= burst_q;
      end else if (busy) begin
        if (tick) begin
          dcnt   <= '0;
          sclk_q <= ~sclk_q;
        end else begin
          dcnt <= dcnt + DIV_W'(1);
        end
        if (rise) sh_rx <= {sh_rx[6:0], spi_miso};
        if (fall) begin
          if (bit_q == 3'd7) begin
            bit_q  <= '0;
            left_q <= left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              busy <= 1'b0;
              cs_q <= 1'b1;
            end
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_tx <= {sh_tx[6:0], 1'b0};
          end
        end
      end
      if (load) begin
        sh_tx    <= nxt_byte;
        txleft_q <= (tl_src != '0) ? tl_src - CNT_W'(1) : '0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[0]  = en_q;
        reg_rdata[1]  = mst_q;
        reg_rdata[4]  = busy;
        reg_rdata[31] = sr_act;
      end
      A_HALF: reg_rdata[DIV_W-1:0] = half_q;
      A_BRST: reg_rdata[CNT_W-1:0] = burst_q;
      A_TXC:  reg_rdata[CNT_W-1:0] = txcnt_q;
      A_STAT: begin
        reg_rdata[6:0]  = 7'(rxl);
        reg_rdata[14:8] = 7'(txl);
        reg_rdata[16]   = busy;
      end
      A_RXD:  if (rxl != '0) reg_rdata[7:0] = rxm[rxr];
      default: ;
    endcase
  end

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = busy & sh_tx[7];

  AST_CS_LOW_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n); // R2
  AST_CS_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> spi_cs_n); // R2
  AST_START_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (en_q && mst_q)); // R7
  AST_SRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_act |=> (!busy && txl == '0 && rxl == '0)); // R8
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rxl <= FULL); // R10
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    txl <= FULL); // R10
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!spi_sclk && spi_cs_n)); // R11

endmodule

// File: tb/sim_spi_burst_master.sv
`timescale 1ns/1ps
module sim_spi_burst_master;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi, cs_n;
  logic miso = 1'b0;

  always #10 clk = ~clk;

  spi_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n));

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // {burst, txcount, pushed, half, seed}
  localparam logic [39:0] VEC [6] = '{
    40'h06_04_04_02_03,
    40'h01_01_01_01_9C,
    40'h05_00_00_03_5A,
    40'h08_08_08_00_F0,
    40'h14_04_04_05_11,
    40'h04_03_01_02_C3
  };

  function automatic logic [7:0] tx_byte(input logic [7:0] s, input int i);
    return s + 8'(i * 29);
  endfunction
  function automatic logic [7:0] sl_byte(input logic [7:0] s, input int i);
    return 8'hA5 ^ s ^ 8'(i * 13 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // slave model and pin monitor, all at the falling clock edge
  int cyc = 0, rises = 0, cs_falls = 0, t1 = 0, t2 = 0;
  int sidx = 0, sbit = 7;
  logic [7:0] sseed = '0, mshift = '0;
  logic [7:0] mcap [80];
  logic prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      cs_falls++;
      sidx = 0; sbit = 7;
      miso = sl_byte(sseed, 0)[7];
    end
    if (!prev_sclk && sclk) begin
      rises++;
      if (rises == 1) t1 = cyc;
      if (rises == 2) t2 = cyc;
      mshift = {mshift[6:0], mosi};
      if (rises % 8 == 0 && rises / 8 <= 80) mcap[rises / 8 - 1] = mshift;
    end
    if (prev_sclk && !sclk) begin
      if (sbit == 0) begin sidx++; sbit = 7; end
      else sbit--;
      miso = sl_byte(sseed, sidx)[sbit];
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d, input bit pop);
    @(negedge clk); addr = a; re = pop;
    #2 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic clear_mon(input logic [7:0] s);
    @(posedge clk); #1;
    rises = 0; cs_falls = 0; t1 = 0; t2 = 0; sseed = s;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 20000; k++) begin
      reg_rd(3'd0, d, 1'b0);
      if (!d[4]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(cs_n == 1'b1, "R1", 32'(cs_n), 1);
    chk(sclk == 1'b0 && mosi == 1'b0, "R1", {sclk, mosi}, 0);
    reg_rd(3'd0, d, 0); chk(d == 0, "R1", d, 0);
    reg_rd(3'd1, d, 0); chk(d == 2, "R1", d, 2);
    reg_rd(3'd4, d, 0); chk(d == 0, "R1", d, 0);

    // table of bursts: R2 R3 R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      logic [7:0] b, tc, pc, h, s, e;
      int bad, exp_per;
      logic [7:0] fa, fe;
      {b, tc, pc, h, s} = VEC[v];
      reg_wr(3'd0, 32'h0000_000C);
      reg_wr(3'd1, 32'(h));
      reg_wr(3'd2, 32'(b));
      reg_wr(3'd3, 32'(tc));
      for (int i = 0; i < int'(pc); i++) reg_wr(3'd5, 32'(tx_byte(s, i)));
      clear_mon(s);
      reg_wr(3'd0, 32'h0000_0013);
      if (v == 4) begin
        reg_rd(3'd4, d, 0);
        chk(d[16] == 1'b1, "R5", 32'(d[16]), 1);
      end
      wait_idle();
      chk(cs_falls == 1, "R2", cs_falls, 1);
      chk(rises == int'(b) * 8, "R2", rises, int'(b) * 8);
      chk(cs_n == 1'b1, "R2", 32'(cs_n), 1);
      bad = 0; fa = 0; fe = 0;
      for (int i = 0; i < int'(b); i++) begin
        e = (i < int'(tc) && i < int'(pc)) ? tx_byte(s, i) : 8'h00;
        if (mcap[i] !== e && bad == 0) begin fa = mcap[i]; fe = e; end
        if (mcap[i] !== e) bad++;
      end
      chk(bad == 0, "R3", 32'(fa), 32'(fe));
      exp_per = (h == 0) ? 2 : 2 * int'(h);
      chk(t2 - t1 == exp_per, "R6", t2 - t1, exp_per);
      reg_rd(3'd4, d, 0);
      chk(d[6:0] == 7'(b), "R5", 32'(d[6:0]), 32'(b));
      chk(d[14:8] == 7'(0), "R5", 32'(d[14:8]), 0);
      bad = 0; fa = 0; fe = 0;
      for (int i = 0; i < int'(b); i++) begin
        reg_rd(3'd6, d, 1);
        if (d[7:0] !== sl_byte(s, i) && bad == 0) begin fa = d[7:0]; fe = sl_byte(s, i); end
        if (d[7:0] !== sl_byte(s, i)) bad++;
      end
      chk(bad == 0, "R4", 32'(fa), 32'(fe));
    end

    // R11 idle pins after a burst
    chk(sclk == 1'b0 && mosi == 1'b0 && cs_n == 1'b1, "R11", {sclk, mosi, cs_n}, 1);

    // R7 no start without enable+master, or with burst 0
    reg_wr(3'd2, 32'd2);
    clear_mon(8'h00);
    reg_wr(3'd0, 32'h0000_0011);
    repeat (20) @(negedge clk);
    reg_rd(3'd0, d, 0);
    chk(cs_falls == 0 && d[4] == 1'b0, "R7", cs_falls, 0);
    reg_wr(3'd0, 32'h0000_0012);
    repeat (20) @(negedge clk);
    reg_rd(3'd0, d, 0);
    chk(cs_falls == 0 && d[4] == 1'b0, "R7", cs_falls, 0);
    reg_wr(3'd2, 32'd0);
    reg_wr(3'd0, 32'h0000_0013);
    repeat (20) @(negedge clk);
    reg_rd(3'd0, d, 0);
    chk(cs_falls == 0 && d[4] == 1'b0, "R7", cs_falls, 0);

    // R9 separate fifo resets
    reg_wr(3'd1, 32'd1);
    reg_wr(3'd2, 32'd3);
    reg_wr(3'd3, 32'd0);
    clear_mon(8'h44);
    reg_wr(3'd0, 32'h0000_0013);
    wait_idle();
    for (int i = 0; i < 5; i++) reg_wr(3'd5, 32'(i));
    reg_rd(3'd4, d, 0);
    chk(d[6:0] == 3 && d[14:8] == 5, "R5", d, 32'h0503);
    reg_wr(3'd0, 32'h0000_0004);
    reg_rd(3'd4, d, 0);
    chk(d[6:0] == 3 && d[14:8] == 0, "R9", d, 32'h0003);
    reg_wr(3'd0, 32'h0000_0008);
    reg_rd(3'd4, d, 0);
    chk(d[6:0] == 0, "R9", d, 0);

    // R10 transmit fifo full
    for (int i = 0; i < 70; i++) reg_wr(3'd5, 32'(i));
    reg_rd(3'd4, d, 0);
    chk(d[14:8] == 64, "R10", 32'(d[14:8]), 64);
    reg_wr(3'd0, 32'h0000_0004);

    // R10 receive fifo full, first 64 kept
    reg_wr(3'd2, 32'd70);
    clear_mon(8'h21);
    reg_wr(3'd0, 32'h0000_0013);
    wait_idle();
    chk(rises == 560, "R2", rises, 560);
    reg_rd(3'd4, d, 0);
    chk(d[6:0] == 64, "R10", 32'(d[6:0]), 64);
    begin
      int bad;
      logic [7:0] fa, fe;
      bad = 0; fa = 0; fe = 0;
      for (int i = 0; i < 64; i++) begin
        reg_rd(3'd6, d, 1);
        if (d[7:0] !== sl_byte(8'h21, i) && bad == 0) begin fa = d[7:0]; fe = sl_byte(8'h21, i); end
        if (d[7:0] !== sl_byte(8'h21, i)) bad++;
      end
      chk(bad == 0, "R10", 32'(fa), 32'(fe));
    end

    // R8 soft reset
    for (int i = 0; i < 3; i++) reg_wr(3'd5, 32'(i));
    reg_wr(3'd2, 32'd5);
    reg_wr(3'd3, 32'd2);
    reg_wr(3'd0, 32'h8000_0003);
    reg_rd(3'd0, d, 0);
    chk(d[31] == 1'b1, "R8", 32'(d[31]), 1);
    begin
      int polls;
      polls = 0;
      for (int k = 0; k < 12; k++) begin
        reg_rd(3'd0, d, 0);
        polls++;
        if (!d[31]) break;
      end
      chk(d[31] == 1'b0 && polls <= 4, "R8", polls, 4);
    end
    reg_rd(3'd4, d, 0); chk(d == 0, "R8", d, 0);
    reg_rd(3'd2, d, 0); chk(d == 0, "R8", d, 0);
    reg_rd(3'd3, d, 0); chk(d == 0, "R8", d, 0);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R11", {cs_n, sclk}, 2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule